// File: doc/BRIEF.md
# CAS-before-RAS Refresh Sequencer

This block keeps an asynchronous DRAM's contents alive. It produces CAS-before-RAS refresh cycles, so the memory steps its own internal row counter and no address is ever driven. A free-running interval timer counts clock cycles and asks for a refresh once per interval. The access controller answers with a grant when the bus is free. The sequencer then pulls all column strobes low, then the row strobe, and releases both after the programmed widths. The write-enable line stays high throughout.

After reset the memory cannot be used yet. The sequencer first waits out a power-up pause. It then requests a burst of initial refresh cycles and keeps its request raised until every one of them has been granted and has completed. Only then does it raise `init_done`, which tells the controller that normal accesses may begin. All timing values are parameters counted in clock cycles. Examples are the pause length, the refresh interval, the CAS setup, the RAS low width and the precharge width. If a grant comes late, one extra refresh interval is remembered, so a single missed interval is made up without loss.

Top module: `cbr_refresh_seq`

## Requirements
- R1: While reset is high, and in the cycle after it, the outputs are inactive: `ras_n`=1, `cas_n`=4'hF, `we_n`=1, `rfsh_req`=0 and `init_done`=0.
- R2: `rfsh_req` stays low for the first PAUSE_CYC clock edges after reset is released. It is high after edge PAUSE_CYC.
- R3: After the pause, `rfsh_req` stays high until INIT_CYCLES refresh cycles have completed. This includes the idle cycles between them. `init_done` rises on the edge that ends the last of these cycles and then stays high until reset.
- R4: A refresh starts on a clock edge where the block is idle and `rfsh_req` and `rfsh_gnt` are both high. From that edge on, `cas_n`=0 with `ras_n`=1 for CSR_CYC cycles. Then `ras_n`=0 with `cas_n`=0 for RAS_LOW_CYC cycles. Then both strobes are high for PRE_CYC cycles before the block is idle again.
- R5: All four bits of `cas_n` always carry the same value, so `cas_n` is either 4'h0 or 4'hF.
- R6: `we_n` is 1 in every cycle, including the cycle in which `ras_n` falls and the cycles on either side of it.
- R7: When `rfsh_req` is low, a high `rfsh_gnt` has no effect: `ras_n` stays 1 and `cas_n` stays 4'hF.
- R8: Once `init_done` is high, `rfsh_req` rises exactly INTERVAL_CYC edges after the later of two events: the end of initialization or the end of the most recent refresh cycle. This holds as long as no grant is given in between.
- R9: At most two refresh requests are held pending. Further interval expiries while two are pending are dropped. After two grants, `rfsh_req` is low.
- R10: Between two refresh cycles, `ras_n` stays high for at least PRE_CYC cycles. On each falling edge of `ras_n`, `cas_n` was already low in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all timing parameters count its cycles |
| rst | input | 1 | Synchronous active-high reset |
| rfsh_gnt | input | 1 | Bus grant from the access controller |
| rfsh_req | output | 1 | Refresh request to the access controller |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 4 | Column strobes, active low, driven together |
| we_n | output | 1 | Write enable, active low, held high |
| init_done | output | 1 | Power-up pause and initial refresh burst complete |

## Verification
The checker watches the strobe relations on every cycle:
- The column strobes always move together.
- The column strobes are low before and throughout each row-strobe low period.
- The row strobe meets its minimum low width and its minimum precharge width.
- A refresh starts only after a request.
- `init_done` never drops.

Other behaviour depends on counting from a known event, so only the bench's scenarios can show it:
- the exact pause length;
- the size of the initial burst;
- the interval reload after each refresh;
- the saturation of the pending count at two;
- the fact that a grant without a request is ignored.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    localparam int unsigned CAS_LINES = 4;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_CAS_SETUP,
        ST_RAS_ACT,
        ST_PRECHG
    } rfsh_state_e;

    typedef struct packed {
        logic                 ras_n;
        logic [CAS_LINES-1:0] cas_n;
        logic                 we_n;
    } strobe_t;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Strobe levels decoded from the sequencer phase
    function automatic strobe_t strobes_for(input rfsh_state_e st);
        strobe_t s;
        s.ras_n = 1'b1;
        s.cas_n = '1;
        s.we_n  = 1'b1;
        case (st)
            ST_CAS_SETUP: s.cas_n = '0;
            ST_RAS_ACT: begin
                s.cas_n = '0;
                s.ras_n = 1'b0;
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int unsigned PERIOD = 780
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic reload,
    output logic tick
);
    localparam int unsigned W = $clog2(PERIOD + 1);

    logic [W-1:0] cnt_q;

    assign tick = en && !reload && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst || !en || reload || cnt_q == '0) begin
            cnt_q <= W'(PERIOD - 1);
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/rfsh_pending.sv
module rfsh_pending #(
    parameter int unsigned MAX_PEND = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic any
);
    localparam int unsigned W = $clog2(MAX_PEND + 1);

    logic [W-1:0] cnt_q;

    assign any = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            case ({inc, dec})
                2'b10: if (cnt_q != W'(MAX_PEND)) cnt_q <= cnt_q + 1'b1;
                2'b01: cnt_q <= cnt_q - 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rfsh_cycle_fsm.sv
module rfsh_cycle_fsm
    import rfsh_pkg::*;
#(
    parameter int unsigned PAUSE_CYC   = 10000,
    parameter int unsigned INIT_CYCLES = 8,
    parameter int unsigned CSR_CYC     = 1,
    parameter int unsigned RAS_LOW_CYC = 3,
    parameter int unsigned PRE_CYC     = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    gnt,
    input  logic    pend_any,
    output logic    req,
    output logic    accept,
    output logic    init_phase,
    output logic    done,
    output logic    init_done,
    output strobe_t strb
);
    localparam int unsigned MAXC = max_of(max_of(PAUSE_CYC, CSR_CYC), max_of(RAS_LOW_CYC, PRE_CYC));
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam int unsigned IW   = $clog2(INIT_CYCLES + 1);

    rfsh_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [IW-1:0] init_left_q;
    logic          init_done_q;

    assign init_phase = (state_q != ST_PAUSE) && !init_done_q;
    assign req        = init_phase || pend_any;
    assign accept     = (state_q == ST_IDLE) && req && gnt;
    assign done       = (state_q == ST_PRECHG) && (cnt_q == '0);
    assign init_done  = init_done_q;
    assign strb       = strobes_for(state_q);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        case (state_q)
            ST_PAUSE: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_CAS_SETUP;
                    cnt_d   = CW'(CSR_CYC - 1);
                end
            end
            ST_CAS_SETUP: begin
                if (cnt_q == '0) begin
                    state_d = ST_RAS_ACT;
                    cnt_d   = CW'(RAS_LOW_CYC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_RAS_ACT: begin
                if (cnt_q == '0) begin
                    state_d = ST_PRECHG;
                    cnt_d   = CW'(PRE_CYC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_PRECHG: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_PAUSE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_PAUSE;
            cnt_q       <= CW'(PAUSE_CYC - 1);
            init_left_q <= IW'(INIT_CYCLES);
            init_done_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (accept && init_phase && init_left_q != '0) begin
                init_left_q <= init_left_q - 1'b1;
            end
            if (done && init_phase && init_left_q == '0) begin
                init_done_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cbr_refresh_seq.sv
module cbr_refresh_seq
    import rfsh_pkg::*;
#(
    parameter int unsigned PAUSE_CYC    = 10000,
    parameter int unsigned INIT_CYCLES  = 8,
    parameter int unsigned INTERVAL_CYC = 780,
    parameter int unsigned CSR_CYC      = 1,
    parameter int unsigned RAS_LOW_CYC  = 3,
    parameter int unsigned PRE_CYC      = 2,
    parameter int unsigned MAX_PEND     = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rfsh_gnt,
    output logic                 rfsh_req,
    output logic                 ras_n,
    output logic [CAS_LINES-1:0] cas_n,
    output logic                 we_n,
    output logic                 init_done
);
    logic    tick, accept, init_phase, done, pend_any;
    strobe_t strb;

    rfsh_interval_timer #(.PERIOD(INTERVAL_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .en     (init_done),
        .reload (done),
        .tick   (tick)
    );

    rfsh_pending #(.MAX_PEND(MAX_PEND)) u_pend (
        .clk (clk),
        .rst (rst),
        .inc (tick),
        .dec (accept && !init_phase),
        .any (pend_any)
    );

    rfsh_cycle_fsm #(
        .PAUSE_CYC   (PAUSE_CYC),
        .INIT_CYCLES (INIT_CYCLES),
        .CSR_CYC     (CSR_CYC),
        .RAS_LOW_CYC (RAS_LOW_CYC),
        .PRE_CYC     (PRE_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .gnt        (rfsh_gnt),
        .pend_any   (pend_any),
        .req        (rfsh_req),
        .accept     (accept),
        .init_phase (init_phase),
        .done       (done),
        .init_done  (init_done),
        .strb       (strb)
    );

    assign ras_n = strb.ras_n;
    assign cas_n = strb.cas_n;
    assign we_n  = strb.we_n;
endmodule

// File: rtl/rfsh_seq_chk.sv
module rfsh_seq_chk #(
    parameter int unsigned RAS_LOW_CYC = 3,
    parameter int unsigned PRE_CYC     = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       rfsh_req,
    input logic       ras_n,
    input logic [3:0] cas_n,
    input logic       init_done
);
    logic [15:0] low_run, high_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run  <= '0;
            high_run <= '0;
        end else begin
            low_run  <= ras_n ? '0 : ((low_run == 16'hFFFF) ? low_run : low_run + 1'b1);
            high_run <= !ras_n ? '0 : ((high_run == 16'hFFFF) ? high_run : high_run + 1'b1);
        end
    end

    // R5
    cas_together_chk: assert property (@(posedge clk) disable iff (rst)
        (cas_n == 4'h0) || (cas_n == 4'hF));

    // R10
    cas_first_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (cas_n == 4'h0) && ($past(cas_n) == 4'h0));

    // R4
    cas_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> (cas_n == 4'h0));

    // R4
    ras_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (low_run >= 16'(RAS_LOW_CYC)));

    // R10
    precharge_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (high_run >= 16'(PRE_CYC)));

    // R7
    start_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n[0]) |-> $past(rfsh_req));

    // R3
    init_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);
endmodule

bind cbr_refresh_seq rfsh_seq_chk #(
    .RAS_LOW_CYC (RAS_LOW_CYC),
    .PRE_CYC     (PRE_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rfsh_req  (rfsh_req),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .init_done (init_done)
);

// File: tb/sim_cbr_refresh_seq.sv
module sim_cbr_refresh_seq;
    localparam int PAUSE    = 50;
    localparam int INTERVAL = 60;
    localparam int NINIT    = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       gnt = 1'b0;
    logic       req, ras_n, we_n, init_done;
    logic [3:0] cas_n;

    int checks = 0;
    int errors = 0;

    // {ras_n, cas_n} after each edge of one refresh, starting at the grant edge
    localparam logic [4:0] CYC_TBL [6] = '{
        5'b1_0000, 5'b0_0000, 5'b0_0000, 5'b0_0000, 5'b1_1111, 5'b1_1111
    };

    always #10 clk = ~clk;

    cbr_refresh_seq #(
        .PAUSE_CYC    (PAUSE),
        .INIT_CYCLES  (NINIT),
        .INTERVAL_CYC (INTERVAL),
        .CSR_CYC      (1),
        .RAS_LOW_CYC  (3),
        .PRE_CYC      (2),
        .MAX_PEND     (2)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .rfsh_gnt  (gnt),
        .rfsh_req  (req),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .init_done (init_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic idle_outputs(input string tag);
        chk({tag, " ras_n/cas_n idle"}, {27'd0, ras_n, cas_n}, 32'h1F);
        chk({tag, " we_n"}, {31'd0, we_n}, 32'd1);
    endtask

    task automatic refresh_cycle(input string tag);
        gnt = 1'b1;
        step();
        gnt = 1'b0;
        for (int i = 0; i < 6; i++) begin
            chk({tag, " R4 R5 R10 strobe phase"}, {27'd0, ras_n, cas_n}, {27'd0, CYC_TBL[i]});
            chk({tag, " R6 we_n high"}, {31'd0, we_n}, 32'd1);
            step();
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog R1..: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #5;
        repeat (3) step();
        // R1 in reset
        idle_outputs("R1");
        chk("R1 req", {31'd0, req}, 32'd0);
        chk("R1 init_done", {31'd0, init_done}, 32'd0);
        rst = 1'b0;
        step();
        idle_outputs("R1 after release");

        // R2 pause length
        for (int i = 1; i < PAUSE - 1; i++) step();
        chk("R2 req low during pause", {31'd0, req}, 32'd0);
        step();
        chk("R2 req high after pause", {31'd0, req}, 32'd1);

        // R3 initial burst
        for (int k = 0; k < NINIT; k++) begin
            refresh_cycle("R3");
            if (k < NINIT - 1) begin
                chk("R3 req held in init", {31'd0, req}, 32'd1);
                chk("R3 init_done still low", {31'd0, init_done}, 32'd0);
            end else begin
                chk("R3 init_done after burst", {31'd0, init_done}, 32'd1);
                chk("R3 req drops after burst", {31'd0, req}, 32'd0);
            end
        end

        // R7 grant without request
        gnt = 1'b1;
        for (int i = 0; i < 10; i++) begin
            step();
            idle_outputs("R7 grant ignored");
        end
        gnt = 1'b0;

        // R8 first interval after init
        for (int i = 10; i < INTERVAL - 1; i++) step();
        chk("R8 req low before interval", {31'd0, req}, 32'd0);
        step();
        chk("R8 req at interval", {31'd0, req}, 32'd1);

        // R9 pending saturation: three expiries, only two kept
        for (int i = 0; i < 125; i++) step();
        chk("R9 req still pending", {31'd0, req}, 32'd1);
        refresh_cycle("R9 first");
        chk("R9 second request kept", {31'd0, req}, 32'd1);
        refresh_cycle("R9 second");
        chk("R9 third expiry dropped", {31'd0, req}, 32'd0);

        // R8 reload on refresh completion
        for (int i = 0; i < INTERVAL - 1; i++) step();
        chk("R8 req low before reload interval", {31'd0, req}, 32'd0);
        step();
        chk("R8 req after reload interval", {31'd0, req}, 32'd1);

        // R1 reset in operation
        rst = 1'b1;
        step();
        idle_outputs("R1 mid-run reset");
        chk("R1 mid-run req", {31'd0, req}, 32'd0);
        chk("R1 mid-run init_done", {31'd0, init_done}, 32'd0);
        rst = 1'b0;
        step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule